// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit resolves the source operand of one decoded instruction for a datapath built around an accumulator. It receives a mode code, a register selector, an index selector, a two-bit scale, an address or displacement word, a flag that picks the short or the full displacement, and a flag asking for the operand to be summed into the accumulator. Depending on the mode, it returns the operand in the same cycle from the instruction word or from a register. Otherwise it issues one read, or two chained reads, on a synchronous data-memory port and returns the read word.

The unit holds eight 32-bit general registers and a stack pointer, each loaded through a simple write port. It contains the effective-address adder with its scaling shifter and a three-state controller. The controller is either idle, waiting for a first read, or waiting for a second read. A new instruction is taken only while the unit is idle, and `instReady` shows that. Every resolved operand appears for exactly one cycle on `opValid`/`opData`.

Top module: `operand_resolver`

## Requirements
- R1: Mode 1 (immediate) returns `instAddr` on `opData` with `opValid` high in the accepting cycle and issues no memory read.
- R2: Mode 2 (direct) issues one read at `instAddr` in the accepting cycle and returns the read word with `opValid` one cycle later.
- R3: Mode 3 (indirect) reads at `instAddr`, then in the next cycle reads at the returned word, and returns the second word two cycles after acceptance. It makes two reads in total.
- R4: Mode 4 (register) returns register `instReg` in the accepting cycle with no memory read.
- R5: Mode 5 (register indirect) makes one read at the contents of register `instReg` and returns the word one cycle later.
- R6: Mode 6 (displacement) makes one read at disp + reg[`instReg`] + (reg[`instIndex`] << `instScale`), modulo 2^32. With `instDispWide`=1, disp is all of `instAddr`. With `instDispWide`=0, disp is `instAddr[7:0]` sign-extended.
- R7: Mode 7 (stack) makes one read at the stack pointer and returns the word one cycle later.
- R8: Mode 0 (implied) returns zero with `opValid` in the accepting cycle and no memory read.
- R9: `instReady` is low in every cycle in which a read is outstanding. An instruction presented then is ignored: it causes no read, no extra `opValid`, and no change to the operand being resolved.
- R10: When the accepted instruction had `instAccAdd`=1, `acc` becomes acc + operand in the cycle after `opValid`. Otherwise `acc` holds its value.
- R11: After reset `acc` is zero, `instReady` is high, `opValid` and `memRe` are low, and all registers and the stack pointer read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Instruction present |
| instReady | output | 1 | Unit idle, instruction taken when valid |
| instMode | input | 3 | Addressing mode code 0..7 |
| instReg | input | 3 | Register selector, base for mode 6 |
| instIndex | input | 3 | Index register selector for mode 6 |
| instScale | input | 2 | Index shift amount 0..3 |
| instAddr | input | 32 | Immediate, address or displacement |
| instDispWide | input | 1 | 1 selects full displacement, 0 the sign-extended low byte |
| instAccAdd | input | 1 | Add operand into accumulator |
| regWe | input | 1 | Register write enable |
| regWaddr | input | 3 | Register write index |
| regWdata | input | 32 | Register write data |
| spWe | input | 1 | Stack pointer load enable |
| spWdata | input | 32 | Stack pointer load value |
| memRe | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memRdata | input | 32 | Read data, valid the cycle after `memRe` |
| opValid | output | 1 | Operand valid strobe |
| opData | output | 32 | Resolved operand |
| acc | output | 32 | Accumulator |

## Verification
A wrong controller state shows up at once at the ports. A skipped second read ends an indirect fetch one cycle early with the pointer word, not the operand. A controller stuck busy leaves `instReady` low and no `opValid` ever arrives. A missing chain flag turns a two-read fetch into a single read. An error in the address adder or the scaling shifter puts a wrong address on `memAddr` in the accepting cycle. The operand returned one cycle later is then the model word of the wrong address. Accumulator faults appear one cycle after the offending `opValid`, and they persist.

// File: rtl/opr_pkg.sv
package opr_pkg;
  typedef enum logic [2:0] {
    MODE_NONE  = 3'd0,
    MODE_IMM   = 3'd1,
    MODE_ABS   = 3'd2,
    MODE_PTR   = 3'd3,
    MODE_REG   = 3'd4,
    MODE_REGPT = 3'd5,
    MODE_BIDX  = 3'd6,
    MODE_STK   = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ1 = 2'd1,
    ST_READ2 = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // instruction taken this cycle
    logic issueEa;   // read at effective address
    logic issuePtr;  // read at returned pointer
    logic outComb;   // operand available without memory
    logic outMem;    // operand is the returned read word
  } ctrl_t;
endpackage

// File: rtl/opr_control.sv
module opr_control
  import opr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [2:0] instMode,
  output logic       ready,
  output ctrl_t      ctrl
);
  state_e state, stateNext;
  logic   chainQ;
  mode_e  mode;

  assign mode  = mode_e'(instMode);
  assign ready = (state == ST_IDLE);

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (instValid) begin
        ctrl.accept = 1'b1;
        if (mode == MODE_NONE || mode == MODE_IMM || mode == MODE_REG) begin
          ctrl.outComb = 1'b1;
        end else begin
          ctrl.issueEa = 1'b1;
          stateNext    = ST_READ1;
        end
      end
      ST_READ1: if (chainQ) begin
        ctrl.issuePtr = 1'b1;
        stateNext     = ST_READ2;
      end else begin
        ctrl.outMem = 1'b1;
        stateNext   = ST_IDLE;
      end
      ST_READ2: begin
        ctrl.outMem = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      chainQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.accept) chainQ <= (mode == MODE_PTR);
    end
  end
endmodule

// File: rtl/opr_datapath.sv
module opr_datapath
  import opr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int REG_N    = 8,
  parameter int SHORT_W  = 8,
  localparam int RSEL_W  = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [2:0]        instMode,
  input  logic [RSEL_W-1:0] instReg,
  input  logic [RSEL_W-1:0] instIndex,
  input  logic [1:0]        instScale,
  input  logic [DATA_W-1:0] instAddr,
  input  logic              instDispWide,
  input  logic              instAccAdd,
  input  logic              regWe,
  input  logic [RSEL_W-1:0] regWaddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              spWe,
  input  logic [DATA_W-1:0] spWdata,
  output logic              memRe,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              opValid,
  output logic [DATA_W-1:0] opData,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] regs [REG_N];
  logic [DATA_W-1:0] sp, ea, dispExt, combOp, scaledIdx;
  logic              accAddQ, doAdd;
  mode_e             mode;

  assign mode = mode_e'(instMode);

  for (genvar g = 0; g < REG_N; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        regs[g] <= '0;
      else if (regWe && regWaddr == g)  regs[g] <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sp <= '0;
    else if (spWe) sp <= spWdata;
  end

  assign dispExt   = instDispWide ? instAddr
                   : {{(DATA_W-SHORT_W){instAddr[SHORT_W-1]}}, instAddr[SHORT_W-1:0]};
  assign scaledIdx = regs[instIndex] << instScale;

  always_comb begin
    unique case (mode)
      MODE_REGPT: ea = regs[instReg];
      MODE_BIDX:  ea = dispExt + regs[instReg] + scaledIdx;
      MODE_STK:   ea = sp;
      default:    ea = instAddr;
    endcase
    unique case (mode)
      MODE_IMM: combOp = instAddr;
      MODE_REG: combOp = regs[instReg];
      default:  combOp = '0;
    endcase
  end

  assign memRe   = ctrl.issueEa | ctrl.issuePtr;
  assign memAddr = ctrl.issuePtr ? memRdata : ea;
  assign opValid = ctrl.outComb | ctrl.outMem;
  assign opData  = ctrl.outMem ? memRdata : combOp;
  assign doAdd   = ctrl.outComb ? instAccAdd : accAddQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAddQ <= 1'b0;
      acc     <= '0;
    end else begin
      if (ctrl.accept)      accAddQ <= instAccAdd;
      if (opValid && doAdd) acc     <= acc + opData;
    end
  end
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
  import opr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_N   = 8,
  parameter int SHORT_W = 8,
  localparam int RSEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [2:0]        instMode,
  input  logic [RSEL_W-1:0] instReg,
  input  logic [RSEL_W-1:0] instIndex,
  input  logic [1:0]        instScale,
  input  logic [DATA_W-1:0] instAddr,
  input  logic              instDispWide,
  input  logic              instAccAdd,
  input  logic              regWe,
  input  logic [RSEL_W-1:0] regWaddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              spWe,
  input  logic [DATA_W-1:0] spWdata,
  output logic              memRe,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              opValid,
  output logic [DATA_W-1:0] opData,
  output logic [DATA_W-1:0] acc
);
  ctrl_t ctrl;

  opr_control uCtl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instMode(instMode),
    .ready(instReady), .ctrl(ctrl)
  );

  opr_datapath #(.DATA_W(DATA_W), .REG_N(REG_N), .SHORT_W(SHORT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .instMode(instMode),
    .instReg(instReg), .instIndex(instIndex), .instScale(instScale),
    .instAddr(instAddr), .instDispWide(instDispWide), .instAccAdd(instAccAdd),
    .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .spWe(spWe), .spWdata(spWdata),
    .memRe(memRe), .memAddr(memAddr), .memRdata(memRdata),
    .opValid(opValid), .opData(opData), .acc(acc)
  );
endmodule

// File: rtl/opr_checker.sv
module opr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic              instReady,
  input logic [2:0]        instMode,
  input logic [DATA_W-1:0] instAddr,
  input logic              memRe,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memRdata,
  input logic              opValid,
  input logic [DATA_W-1:0] opData,
  input logic [DATA_W-1:0] acc
);
  logic take;
  assign take = instValid && instReady;

  AST_IMM_PASS: assert property (@(posedge clk) disable iff (!rstN)
    take && instMode == 3'd1 |-> opValid && opData == instAddr && !memRe); // R1

  AST_DIRECT_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    take && instMode == 3'd2 |-> memRe && memAddr == instAddr); // R2

  AST_DIRECT_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    take && instMode == 3'd2 |=> opValid && !memRe && opData == memRdata); // R2

  AST_CHAIN_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    take && instMode == 3'd3 |=> memRe && memAddr == memRdata && !opValid); // R3

  AST_IMPLIED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    take && instMode == 3'd0 |-> opValid && opData == '0 && !memRe); // R8

  AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !instReady); // R9

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(acc)); // R10
endmodule

bind operand_resolver opr_checker #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/sim_operand_resolver.sv
module sim_operand_resolver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic        instReady;
  logic [2:0]  instMode = '0, instReg = '0, instIndex = '0;
  logic [1:0]  instScale = '0;
  logic [31:0] instAddr = '0;
  logic        instDispWide = 1'b0, instAccAdd = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regWaddr = '0;
  logic [31:0] regWdata = '0;
  logic        spWe = 1'b0;
  logic [31:0] spWdata = '0;
  logic        memRe;
  logic [31:0] memAddr;
  logic [31:0] memRdata = '0;
  logic        opValid;
  logic [31:0] opData, acc;

  int compared = 0, mismatched = 0;
  logic [31:0] regM [8];
  logic [31:0] spM = '0, accM = '0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  operand_resolver u0 (.*);

  function automatic logic [31:0] memFn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F ^ {a[15:0], a[31:16]};
  endfunction

  // synchronous memory model, one-cycle latency
  always_ff @(posedge clk) if (memRe) memRdata <= memFn(memAddr);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic writeReg(logic [2:0] i, logic [31:0] v);
    @(negedge clk); regWe = 1; regWaddr = i; regWdata = v;
    @(negedge clk); regWe = 0;
    regM[i] = v;
  endtask

  task automatic loadSp(logic [31:0] v);
    @(negedge clk); spWe = 1; spWdata = v;
    @(negedge clk); spWe = 0;
    spM = v;
  endtask

  function automatic string reqOf(logic [2:0] m);
    case (m)
      3'd0: return "R8"; 3'd1: return "R1"; 3'd2: return "R2"; 3'd3: return "R3";
      3'd4: return "R4"; 3'd5: return "R5"; 3'd6: return "R6"; default: return "R7";
    endcase
  endfunction

  // intrude: present a second instruction while busy (R9)
  task automatic runInst(logic [2:0] m, logic [2:0] r, logic [2:0] x, logic [1:0] s,
                         logic [31:0] a, logic wide, logic add, bit intrude);
    logic [31:0] expOp, ea, disp;
    int expLat, lat, reads;
    case (m)
      3'd0: begin expOp = 0; expLat = 0; end
      3'd1: begin expOp = a; expLat = 0; end
      3'd2: begin expOp = memFn(a); expLat = 1; end
      3'd3: begin expOp = memFn(memFn(a)); expLat = 2; end
      3'd4: begin expOp = regM[r]; expLat = 0; end
      3'd5: begin expOp = memFn(regM[r]); expLat = 1; end
      3'd6: begin
        disp = wide ? a : {{24{a[7]}}, a[7:0]};
        ea = disp + regM[r] + (regM[x] << s);
        expOp = memFn(ea); expLat = 1;
      end
      default: begin expOp = memFn(spM); expLat = 1; end
    endcase
    @(negedge clk);
    instValid = 1; instMode = m; instReg = r; instIndex = x; instScale = s;
    instAddr = a; instDispWide = wide; instAccAdd = add;
    #1;
    check("R9", 32'(instReady), 1, "ready when idle");
    lat = 0; reads = 0;
    while (1) begin
      if (memRe) reads++;
      if (opValid) break;
      @(negedge clk);
      if (intrude) begin
        instValid = 1; instMode = 3'd1; instAddr = 32'hDEAD_BEEF; instAccAdd = 0;
      end else instValid = 0;
      #1;
      if (intrude) check("R9", 32'(instReady), 0, "ready while busy");
      lat++;
      if (lat > 5) break;
    end
    check(reqOf(m), opData, expOp, "operand");
    check(reqOf(m), lat, expLat, "latency");
    check(reqOf(m), reads, expLat, "read count");
    if (add) accM = accM + expOp;
    @(negedge clk);
    instValid = 0;
    #1;
    check("R10", acc, accM, "accumulator");
    if (intrude) check("R9", 32'(opValid), 0, "no extra operand");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regM[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R11", acc, 0, "acc reset");
    check("R11", 32'(instReady), 1, "ready reset");
    check("R11", 32'(opValid), 0, "opValid reset");
    check("R11", 32'(memRe), 0, "memRe reset");
    @(negedge clk); rstN = 1;
    // registers read zero after reset
    runInst(3'd4, 3'd5, 0, 0, 0, 0, 0, 0);                 // R11 R4
    runInst(3'd7, 0, 0, 0, 0, 0, 0, 0);                    // R11 R7 sp=0

    // directed cases
    runInst(3'd0, 0, 0, 0, 32'h1234, 0, 1, 0);             // R8 adds zero
    runInst(3'd1, 0, 0, 0, 32'hFFFF_FFF0, 0, 1, 0);        // R1
    runInst(3'd1, 0, 0, 0, 32'h0000_0020, 0, 1, 0);        // R1 + R10 wrap
    runInst(3'd2, 0, 0, 0, 32'h0000_0100, 0, 1, 0);        // R2
    runInst(3'd3, 0, 0, 0, 32'h0000_0200, 0, 1, 0);        // R3
    writeReg(3'd1, 32'h1000_0000);
    writeReg(3'd2, 32'h0000_0040);
    writeReg(3'd7, 32'hFFFF_FFFF);
    runInst(3'd4, 3'd1, 0, 0, 0, 0, 0, 0);                 // R4
    runInst(3'd5, 3'd1, 0, 0, 0, 0, 1, 0);                 // R5
    runInst(3'd6, 3'd1, 3'd2, 2'd3, 32'h0000_0080, 0, 0, 0); // R6 negative short disp
    runInst(3'd6, 3'd1, 3'd2, 2'd0, 32'h0000_007F, 0, 0, 0); // R6 positive short disp
    runInst(3'd6, 3'd7, 3'd7, 2'd2, 32'h8000_0080, 1, 1, 0); // R6 wide disp, wrap
    runInst(3'd6, 3'd2, 3'd1, 2'd1, 32'hABCD_EF12, 0, 0, 0); // R6 high bits ignored
    loadSp(32'h0000_3000);
    runInst(3'd7, 0, 0, 0, 0, 0, 1, 0);                    // R7
    runInst(3'd3, 0, 0, 0, 32'h0000_0444, 0, 0, 1);        // R9 busy ignore
    runInst(3'd2, 0, 0, 0, 32'h0000_0555, 0, 1, 1);        // R9 busy ignore

    // constrained random
    void'($urandom(32'd1357));
    for (int n = 0; n < 80; n++) begin
      if (n % 10 == 0) writeReg(3'($urandom), $urandom);
      if (n % 25 == 0) loadSp($urandom);
      runInst(3'($urandom), 3'($urandom), 3'($urandom), 2'($urandom),
              ($urandom % 3 == 0) ? 32'($urandom % 256) : $urandom,
              1'($urandom), 1'($urandom), ($urandom % 8 == 0));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule